// File: doc/BRIEF.md
# Clock Source Mode Controller

This block picks the system clock from three candidates: a free-running internal reference, an external reference that must first settle, and the output of a frequency-locking loop. Software drives a small set of request inputs: which clock feeds the system, which reference the loop follows, which loop variant is active, whether the external oscillator is powered, and a power-of-two divider for the external reference. For each request there is a matching status output. A status output moves to the new value only once the hardware has actually finished the change, so software polls the status before taking its next step.

The switch between clocks goes through a glitch-free multiplexer. Each source has its own two-flop enable synchronizer, clocked on the falling edge of that source. A new source is enabled only after every other source has gated itself off on its own edge. An oscillator-startup counter counts external reference edges before the oscillator is declared ready. The loop is stood in for by a lock counter. It counts reference ticks and restarts whenever its reference, its divider or its variant changes. All bookkeeping runs on a control clock `clk`, into which the reference clocks are synchronized.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the status reads source 01 (internal), reference-internal 1, loop variant 0, oscillator ready 0 and lock 0.
- R2: Source code 00 selects the loop clock, 01 the internal reference and 10 the external reference. Once `st_src` shows a code, `sys_clk` equals that source's clock.
- R3: `st_src` does not change in the control cycle after a new source request. It changes only once the enable handshake between the old and new clocks has completed.
- R4: Source code 11 is reserved. Requesting it leaves both the selection and `st_src` unchanged.
- R5: No more than one source gate is ever enabled at a time, so `sys_clk` never carries pieces of two clocks.
- R6: With `req_ext_en` high, `st_osc_ready` rises after OSC_CYC rising edges of `ext_clk`. With `req_ext_en` low, it is held clear.
- R7: Divider code k divides the external reference by 2^k (001 gives 2, 010 gives 4). With the external reference selected, lock therefore takes LOCK_LEN·2^k external edges.
- R8: `st_lock` clears in the cycle after any change of reference select, divider code or loop variant. It rises again after LOCK_LEN reference ticks.
- R9: `st_ref_int` clears only while the oscillator is ready. It returns to 1 within two control cycles of a request for the internal reference.
- R10: `st_loop_sel` takes a new loop variant only when the loop has locked again with that variant. The loop keeps running and locks while the external source drives the system.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for all bookkeeping |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_clk | input | 1 | Internal reference clock |
| ext_clk | input | 1 | External reference clock (oscillator output) |
| loop_clk | input | 1 | Loop output clock |
| req_src | input | 2 | Requested system clock source |
| req_ref_int | input | 1 | 1: loop follows internal reference, 0: external |
| req_loop_sel | input | 1 | Requested loop variant |
| req_ext_en | input | 1 | Power the external oscillator |
| req_div | input | DIV_BITS | External reference divider code (ratio 2^code) |
| sys_clk | output | 1 | Glitch-free system clock |
| st_src | output | 2 | Source actually driving `sys_clk` |
| st_ref_int | output | 1 | Reference actually followed by the loop |
| st_loop_sel | output | 1 | Loop variant the loop is locked with |
| st_osc_ready | output | 1 | External oscillator finished startup |
| st_lock | output | 1 | Loop lock flag |

## Verification
The bench builds the block with OSC_CYC = 16, LOCK_LEN = 8 and DIV_BITS = 3. These values keep oscillator startup and every relock to a few dozen reference edges. The bench can therefore count edges exactly, and can tell a divide-by-2 lock (16 edges) from a divide-by-4 lock (32 edges) within a short run. The reference clocks run at periods of 40, 30 and 12 ns against a 5 ns control clock. This keeps every reference edge visible to the synchronizers, and makes each handshake between sources slow enough that the bench can see the status lag behind the request.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_LOOP = 2'b00,
    SRC_INT  = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_RSVD = 2'b11
  } src_sel_e;

  // ratio applied to the external reference for a divider code
  function automatic int unsigned div_ratio(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // source code of a one-hot enable vector (bit index equals code)
  function automatic logic [1:0] onehot_to_src(input logic [NSRC-1:0] oh);
    logic [1:0] r;
    r = 2'b00;
    for (int i = 0; i < NSRC; i++)
      if (oh[i]) r = 2'(i);
    return r;
  endfunction

endpackage

// File: rtl/cmc_edge_sync.sv
module cmc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], async_i};
  end

  assign rise_o = sh[1] & ~sh[2];
endmodule

// File: rtl/cmc_osc_startup.sv
module cmc_osc_startup #(
  parameter int OSC_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic edge_i,
  output logic ready_o
);
  localparam int CW = $clog2(OSC_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(OSC_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ready_o <= 1'b0;
    end else if (!en_i) begin
      cnt     <= '0;
      ready_o <= 1'b0;
    end else if (edge_i && !ready_o) begin
      if (cnt == LAST) ready_o <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cmc_ref_divider.sv
module cmc_ref_divider
  import cmc_pkg::*;
#(
  parameter int DIV_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                restart_i,
  input  logic                edge_i,
  input  logic [DIV_BITS-1:0] code_i,
  output logic                tick_o
);
  localparam int CW = (1 << DIV_BITS) - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = CW'(div_ratio(int'(code_i)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (restart_i || !run_i) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (edge_i) begin
      if (cnt == limit) begin
        cnt    <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmc_lock_detect.sv
module cmc_lock_detect #(
  parameter int LOCK_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic tick_i,
  output logic lock_o
);
  localparam int LW = $clog2(LOCK_LEN + 1);
  localparam logic [LW-1:0] LAST = LW'(LOCK_LEN - 1);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      lock_o <= 1'b0;
    end else if (restart_i) begin
      cnt    <= '0;
      lock_o <= 1'b0;
    end else if (tick_i && !lock_o) begin
      if (cnt == LAST) lock_o <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cmc_gate_cell.sv
module cmc_gate_cell #(
  parameter bit RST_ON = 1'b0
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic others_off_i,
  output logic en_o
);
  logic s1;

  // both stages advance on the falling edge of the source itself
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= RST_ON;
      en_o <= RST_ON;
    end else begin
      s1   <= want_i & others_off_i;
      en_o <= s1;
    end
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int OSC_CYC  = 4096,
  parameter int LOCK_LEN = 1024,
  parameter int DIV_BITS = 3
) (
  input  logic                int_clk,
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_clk,
  input  logic                loop_clk,
  input  logic [1:0]          req_src,
  input  logic                req_ref_int,
  input  logic                req_loop_sel,
  input  logic                req_ext_en,
  input  logic [DIV_BITS-1:0] req_div,
  output logic                sys_clk,
  output logic [1:0]          st_src,
  output logic                st_ref_int,
  output logic                st_loop_sel,
  output logic                st_osc_ready,
  output logic                st_lock
);
  localparam logic [NSRC-1:0] EN_RST = NSRC'(1) << SRC_INT;

  // request registers
  logic [1:0]          eff_src;
  logic [1:0]          mux_sel;
  logic                ref_q;
  logic                loop_q;
  logic [DIV_BITS-1:0] div_q;

  // named internal events
  logic                chg;
  logic                int_rise;
  logic                ext_rise;
  logic                div_tick;
  logic                lock_tick;
  logic [NSRC-1:0]     en_vec;
  logic [NSRC-1:0]     en_s1, en_s2;
  logic [NSRC-1:0]     src_clks;
  logic [NSRC-1:0]     want;
  logic [NSRC-1:0]     others_off;

  assign chg = (req_ref_int != ref_q) || (req_div != div_q) ||
               (req_loop_sel != loop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_src <= SRC_INT;
      mux_sel <= SRC_INT;
      ref_q   <= 1'b1;
      loop_q  <= 1'b0;
      div_q   <= '0;
    end else begin
      ref_q  <= req_ref_int;
      loop_q <= req_loop_sel;
      div_q  <= req_div;
      if (req_src != SRC_RSVD) eff_src <= req_src;
      // an external selection reaches the mux only once the oscillator runs
      if (eff_src != SRC_EXT || st_osc_ready) mux_sel <= eff_src;
    end
  end

  // reference edges into the control domain
  cmc_edge_sync u_int_sync (
    .clk(clk), .rst_n(rst_n), .async_i(int_clk), .rise_o(int_rise)
  );
  cmc_edge_sync u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_clk), .rise_o(ext_rise)
  );

  cmc_osc_startup #(.OSC_CYC(OSC_CYC)) u_osc (
    .clk(clk), .rst_n(rst_n), .en_i(req_ext_en), .edge_i(ext_rise),
    .ready_o(st_osc_ready)
  );

  cmc_ref_divider #(.DIV_BITS(DIV_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(st_osc_ready), .restart_i(chg),
    .edge_i(ext_rise), .code_i(div_q), .tick_o(div_tick)
  );

  assign lock_tick = ref_q ? int_rise : div_tick;

  cmc_lock_detect #(.LOCK_LEN(LOCK_LEN)) u_lock (
    .clk(clk), .rst_n(rst_n), .restart_i(chg), .tick_i(lock_tick),
    .lock_o(st_lock)
  );

  // glitch-free multiplexer: index equals the source code
  assign src_clks = {ext_clk, int_clk, loop_clk};

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    localparam logic [NSRC-1:0] SELF = NSRC'(1) << i;
    assign want[i]       = (mux_sel == 2'(i));
    assign others_off[i] = ~|(en_vec & ~SELF);
    cmc_gate_cell #(.RST_ON(i == int'(SRC_INT))) u_cell (
      .src_clk(src_clks[i]), .rst_n(rst_n), .want_i(want[i]),
      .others_off_i(others_off[i]), .en_o(en_vec[i])
    );
  end

  assign sys_clk = |(src_clks & en_vec);

  // status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1       <= EN_RST;
      en_s2       <= EN_RST;
      st_src      <= SRC_INT;
      st_ref_int  <= 1'b1;
      st_loop_sel <= 1'b0;
    end else begin
      en_s1 <= en_vec;
      en_s2 <= en_s1;
      if ($onehot(en_s2)) st_src <= onehot_to_src(en_s2);
      if (ref_q)             st_ref_int <= 1'b1;
      else if (st_osc_ready) st_ref_int <= 1'b0;
      if (st_lock && !chg)   st_loop_sel <= loop_q;
    end
  end
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_src,
  input logic       req_ext_en,
  input logic [2:0] en_vec,
  input logic       chg,
  input logic [1:0] eff_src,
  input logic [1:0] st_src,
  input logic       st_ref_int,
  input logic       st_loop_sel,
  input logic       st_osc_ready,
  input logic       st_lock
);
  // R5
  one_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_vec));

  // R2
  src_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_src != 2'b11);

  // R4
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_src == 2'b11) |=> $stable(eff_src));

  // R6
  osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ext_en |=> !st_osc_ready);

  // R8
  lock_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !st_lock);

  // R9
  ref_ext_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_ref_int) |-> $past(st_osc_ready));

  // R10
  loop_st_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_loop_sel) |-> $past(st_lock));
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_src(req_src), .req_ext_en(req_ext_en),
  .en_vec(en_vec), .chg(chg), .eff_src(eff_src), .st_src(st_src),
  .st_ref_int(st_ref_int), .st_loop_sel(st_loop_sel),
  .st_osc_ready(st_osc_ready), .st_lock(st_lock)
);

// File: tb/clk_mode_ctrl_tb.sv
`timescale 1ns/1ps
module clk_mode_ctrl_tb;
  localparam int OSC  = 16;
  localparam int LOCK = 8;
  localparam int DB   = 3;

  logic clk = 0, int_clk = 0, ext_clk = 0, loop_clk = 0, rst_n = 0;
  logic [1:0] req_src = 2'b01;
  logic req_ref_int = 1, req_loop_sel = 0, req_ext_en = 0;
  logic [DB-1:0] req_div = '0;
  logic sys_clk, st_ref_int, st_loop_sel, st_osc_ready, st_lock;
  logic [1:0] st_src;

  always #2.5 clk = ~clk;
  always #20  int_clk = ~int_clk;
  always #15  ext_clk = ~ext_clk;
  always #6   loop_clk = ~loop_clk;

  clk_mode_ctrl #(.OSC_CYC(OSC), .LOCK_LEN(LOCK), .DIV_BITS(DB)) u_dut (
    .int_clk(int_clk), .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
    .loop_clk(loop_clk), .req_src(req_src), .req_ref_int(req_ref_int),
    .req_loop_sel(req_loop_sel), .req_ext_en(req_ext_en), .req_div(req_div),
    .sys_clk(sys_clk), .st_src(st_src), .st_ref_int(st_ref_int),
    .st_loop_sel(st_loop_sel), .st_osc_ready(st_osc_ready), .st_lock(st_lock)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    string req;
    int    src;
    bit    refi;
    bit    loop;
    bit    osc;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int pack_st(int s, bit r, bit l, bit o);
    return (s << 3) | (int'(r) << 2) | (int'(l) << 1) | int'(o);
  endfunction

  // driver: apply requests and push the settled status they must lead to
  task automatic drive(input string req, input logic [1:0] s, input bit r,
                       input bit l, input bit e, input int d,
                       input int es, input bit er, input bit el, input bit eo);
    exp_t it;
    @(negedge clk);
    req_src = s; req_ref_int = r; req_loop_sel = l; req_ext_en = e;
    req_div = DB'(d);
    it.req = req; it.src = es; it.refi = er; it.loop = el; it.osc = eo;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // monitor: pop each expected status, wait for it to settle, compare
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t it;
        int guard, act, exp;
        it = sb_q[0];
        exp = pack_st(it.src, it.refi, it.loop, it.osc);
        guard = 0;
        act = pack_st(st_src, st_ref_int, st_loop_sel, st_osc_ready);
        while (act != exp && guard < 3000) begin
          @(negedge clk);
          guard++;
          act = pack_st(st_src, st_ref_int, st_loop_sel, st_osc_ready);
        end
        check(act == exp, it.req, act, exp);
        void'(sb_q.pop_front());
      end
    end
  end

  // count reference edges until lock; lock must first have cleared
  task automatic lock_edges(input string req, input bit use_ext, input int exp);
    int n;
    repeat (2) @(negedge clk);
    check(st_lock == 1'b0, "R8 lock cleared after change", int'(st_lock), 0);
    n = 0;
    while (n < 400) begin
      if (use_ext) @(posedge ext_clk); else @(posedge int_clk);
      if (st_lock) break;
      n++;
    end
    check(n >= exp - 1 && n <= exp + 1, req, n, exp);
  endtask

  // R2 / R5: sys_clk must track the chosen source cleanly
  task automatic follow(input string req, input int sel);
    int bad = 0;
    repeat (4) begin
      case (sel)
        0: begin @(posedge loop_clk); #2; if (sys_clk !== 1'b1) bad++;
                 @(negedge loop_clk); #2; if (sys_clk !== 1'b0) bad++; end
        1: begin @(posedge int_clk); #3; if (sys_clk !== 1'b1) bad++;
                 @(negedge int_clk); #3; if (sys_clk !== 1'b0) bad++; end
        default: begin @(posedge ext_clk); #3; if (sys_clk !== 1'b1) bad++;
                 @(negedge ext_clk); #3; if (sys_clk !== 1'b0) bad++; end
      endcase
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1 reset values
    check(pack_st(st_src, st_ref_int, st_loop_sel, st_osc_ready) == pack_st(1,1,0,0),
          "R1 reset status", pack_st(st_src, st_ref_int, st_loop_sel, st_osc_ready),
          pack_st(1,1,0,0));
    check(st_lock == 1'b0, "R1 reset lock", int'(st_lock), 0);
    rst_n = 1;

    // R8: lock on the internal reference after LOCK ticks
    n = 0;
    while (n < 400) begin
      @(posedge int_clk);
      if (st_lock) break;
      n++;
    end
    check(n >= LOCK - 1 && n <= LOCK + 1, "R8 internal lock edges", n, LOCK);
    follow("R2 internal source after reset", 1);

    // R6: oscillator startup
    drive("R6 oscillator ready", 2'b01, 1, 0, 1, 0, 1, 1, 0, 1);
    n = 0;
    while (n < 400) begin
      @(posedge ext_clk);
      if (st_osc_ready) break;
      n++;
    end
    check(n >= OSC - 1 && n <= OSC + 1, "R6 startup edges", n, OSC);
    drain();

    // R7 / R9: external reference divided by 2
    drive("R9 reference external", 2'b01, 0, 0, 1, 1, 1, 0, 0, 1);
    lock_edges("R7 divide-by-2 lock edges", 1, LOCK * 2);
    drain();

    // R7: divide by 4
    drive("R7 divider change", 2'b01, 0, 0, 1, 2, 1, 0, 0, 1);
    lock_edges("R7 divide-by-4 lock edges", 1, LOCK * 4);
    drain();

    // R3: switch system clock to the external reference
    drive("R2 external source status", 2'b10, 0, 0, 1, 2, 2, 0, 0, 1);
    @(negedge clk);
    check(st_src == 2'b01, "R3 status not yet switched", st_src, 1);
    drain();
    follow("R2 R5 sys_clk follows external", 2);

    // R4: reserved code ignored
    drive("R4 reserved code", 2'b11, 0, 0, 1, 2, 2, 0, 0, 1);
    repeat (300) @(negedge clk);
    check(st_src == 2'b10, "R4 selection kept", st_src, 2);
    follow("R4 sys_clk still external", 2);
    drain();

    // R10: new loop variant while bypassed on the external source
    drive("R10 loop variant status", 2'b10, 0, 1, 1, 2, 2, 0, 1, 1);
    @(negedge clk);
    check(st_loop_sel == 1'b0, "R10 variant held before relock", st_loop_sel, 0);
    lock_edges("R10 relock while bypassed", 1, LOCK * 4);
    drain();
    check(st_lock == 1'b1, "R10 loop locked in bypass", st_lock, 1);

    // R2: loop output as system clock
    drive("R2 loop source status", 2'b00, 0, 1, 1, 2, 0, 0, 1, 1);
    drain();
    follow("R2 R5 sys_clk follows loop", 0);

    // R2: back to the internal reference
    drive("R2 internal source status", 2'b01, 0, 1, 1, 2, 1, 0, 1, 1);
    drain();
    follow("R2 sys_clk follows internal", 1);

    // R9: reference back to internal within two cycles
    drive("R9 reference internal", 2'b01, 1, 1, 1, 2, 1, 1, 1, 1);
    repeat (2) @(negedge clk);
    check(st_ref_int == 1'b1, "R9 internal reference prompt", st_ref_int, 1);
    drain();

    // R6: oscillator disabled
    drive("R6 oscillator off", 2'b01, 1, 1, 0, 2, 1, 1, 1, 0);
    drain();

    repeat (10) @(negedge clk);
    summary();
  end
endmodule